// File: doc/BRIEF.md
# Selectable Expansion-Bus Clock Divider

This block produces the clock for a slow expansion bus from the fast processor input clock. A 3-bit select code picks the source. One choice is a separate fixed reference clock of about 7.16 MHz. The other choices divide the processor input clock by 4, 5, 6, 8, 10 or 12. Alongside the bus clock, the block gives a one-cycle tick in the processor clock domain for logic that starts bus activity on each bus-clock period.

All logic runs in the processor clock domain, and the bus clock is a registered signal. The reference clock is assumed to be much slower than the processor clock. It is brought in through a synchronizer and reproduced on the output. A new select code is held back until the current output period ends, so a change of code never produces a shortened high or low phase. Reset selects the reference source and keeps the output low until the first rising edge of the reference.

Top module: `busclk_div`

## Requirements
- R1: While reset is asserted, `bus_clk_o` and `tick_o` are low from the clock edge after reset is first sampled.
- R2: Select codes 1, 2, 3, 4, 5 and 6 give a bus-clock period of 4, 5, 6, 8, 10 and 12 processor clock cycles respectively.
- R3: In divide mode each period starts high. The high phase lasts floor(N/2) cycles and the low phase lasts the rest, so the divisor 5 gives 2 cycles high and 3 low.
- R4: Select code 0 reproduces the reference clock on `bus_clk_o`. Each high and low phase matches the reference phase, measured in processor cycles.
- R5: Select code 7 is illegal and behaves exactly like code 0.
- R6: A changed select code takes effect only at the end of the current output period. In divide mode that is after the last low cycle. In reference mode it is at the next rising reference edge. After a switch into reference mode the output stays low until a rising reference edge.
- R7: No high or low phase of `bus_clk_o` is shorter than 2 processor cycles, including across any change of select code, provided each reference phase lasts at least 2 processor cycles.
- R8: `tick_o` is high for exactly the cycles in which `bus_clk_o` is high after being low in the previous cycle, so there is one tick per period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Processor input clock; all logic runs on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| ref_clk_i | input | 1 | Fixed reference clock, asynchronous and slower than clk_i |
| sel_i | input | 3 | Source select code (0/7 reference, 1..6 divide by 4,5,6,8,10,12) |
| bus_clk_o | output | 1 | Generated expansion-bus clock |
| tick_o | output | 1 | One-cycle pulse in the cycle the bus clock rises |

## Verification
The hardest case to reach is a code change in the middle of a period, because that is where a runt phase would appear. The bench waits for a sampled rising edge of the bus clock, changes the code one cycle later, and measures the rest of the old period and then the first new period. It does this for slow-to-fast and fast-to-slow divide switches and for switches into reference mode. It then applies random codes at random offsets within a period, while a monitor checks every phase length and every tick.

// File: rtl/busclk_div_pkg.sv
package busclk_div_pkg;

    localparam int SEL_W   = 3;
    localparam int MAX_DIV = 12;
    localparam int DIV_W   = $clog2(MAX_DIV + 1);

    typedef logic [SEL_W-1:0] sel_t;
    typedef logic [DIV_W-1:0] div_t;

    typedef struct packed {
        sel_t act;     // select code currently in force
        logic ref_ok;  // reference mode: a rising reference edge was seen
        logic bclk;    // registered bus clock
        logic tick;    // rise marker
    } bclk_state_t;

    // Divisor for a select code; 0 means the reference clock is used.
    function automatic div_t divisor_of(sel_t code);
        div_t n;
        case (code)
            3'd1:    n = div_t'(4);
            3'd2:    n = div_t'(5);
            3'd3:    n = div_t'(6);
            3'd4:    n = div_t'(8);
            3'd5:    n = div_t'(10);
            3'd6:    n = div_t'(12);
            default: n = div_t'(0);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/busclk_sel_decode.sv
module busclk_sel_decode
    import busclk_div_pkg::*;
(
    input  sel_t code_i,
    output logic is_ref_o,
    output div_t div_n_o,
    output div_t hi_n_o
);
    div_t n;

    always_comb begin
        n        = divisor_of(code_i);
        is_ref_o = (n == '0);          // codes 0 and 7 fall back to reference
        div_n_o  = n;
        hi_n_o   = n >> 1;             // shorter half is the high phase
    end
endmodule

// File: rtl/busclk_ref_sync.sv
module busclk_ref_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic ref_i,
    output logic level_o,
    output logic rise_o
);
    localparam int CHAIN_W = (STAGES < 2) ? 2 : STAGES;

    logic [CHAIN_W-1:0] chain_d, chain_q;
    logic               prev_d, prev_q;

    always_comb begin
        chain_d = {chain_q[CHAIN_W-2:0], ref_i};
        prev_d  = chain_q[CHAIN_W-1];
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= chain_d;
            prev_q  <= prev_d;
        end
    end

    assign level_o = chain_q[CHAIN_W-1];
    assign rise_o  = chain_q[CHAIN_W-1] & ~prev_q;
endmodule

// File: rtl/busclk_phase_ctr.sv
module busclk_phase_ctr
    import busclk_div_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic hold_i,     // keep at zero (reference mode)
    input  logic restart_i,  // start a new period
    input  div_t div_n_i,
    output div_t cnt_d_o,
    output logic at_end_o
);
    div_t cnt_d, cnt_q;

    always_comb begin
        if (hold_i || restart_i) cnt_d = '0;
        else                     cnt_d = cnt_q + div_t'(1);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) cnt_q <= '0;
        else       cnt_q <= cnt_d;
    end

    assign cnt_d_o  = cnt_d;
    assign at_end_o = (cnt_q == div_n_i - div_t'(1));
endmodule

// File: rtl/busclk_div.sv
module busclk_div
    import busclk_div_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       ref_clk_i,
    input  logic [2:0] sel_i,
    output logic       bus_clk_o,
    output logic       tick_o
);
    bclk_state_t st_d, st_q;

    logic cur_ref, nxt_ref, ref_lvl, ref_rise, at_end, boundary;
    div_t cur_div, cur_hi, nxt_div, nxt_hi, cnt_d;
    sel_t act_d;

    busclk_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .ref_i  (ref_clk_i),
        .level_o(ref_lvl),
        .rise_o (ref_rise)
    );

    busclk_sel_decode u_dec_cur (
        .code_i  (st_q.act),
        .is_ref_o(cur_ref),
        .div_n_o (cur_div),
        .hi_n_o  (cur_hi)
    );

    // Period ends: last low cycle in divide mode, rising reference edge otherwise.
    assign boundary = cur_ref ? ref_rise : at_end;
    assign act_d    = boundary ? sel_t'(sel_i) : st_q.act;

    busclk_sel_decode u_dec_nxt (
        .code_i  (act_d),
        .is_ref_o(nxt_ref),
        .div_n_o (nxt_div),
        .hi_n_o  (nxt_hi)
    );

    busclk_phase_ctr u_ctr (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .hold_i   (cur_ref),
        .restart_i(boundary),
        .div_n_i  (cur_div),
        .cnt_d_o  (cnt_d),
        .at_end_o (at_end)
    );

    always_comb begin
        st_d     = st_q;
        st_d.act = act_d;
        if (nxt_ref) begin
            // Entering reference mode from divide mode: wait for a fresh rise.
            st_d.ref_ok = cur_ref ? (st_q.ref_ok | ref_rise) : 1'b0;
            st_d.bclk   = st_d.ref_ok & ref_lvl;
        end else begin
            st_d.ref_ok = 1'b0;
            st_d.bclk   = (cnt_d < nxt_hi);
        end
        st_d.tick = st_d.bclk & ~st_q.bclk;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '{act: '0, ref_ok: 1'b0, bclk: 1'b0, tick: 1'b0};
        else       st_q <= st_d;
    end

    assign bus_clk_o = st_q.bclk;
    assign tick_o    = st_q.tick;

    logic unused_ok;
    assign unused_ok = ^{nxt_div, cur_hi};
endmodule

// File: rtl/busclk_div_chk.sv
module busclk_div_chk (
    input logic       clk_i,
    input logic       rst_i,
    input logic       ref_clk_i,
    input logic [2:0] sel_i,
    input logic       bus_clk_o,
    input logic       tick_o
);
    logic [7:0] run_q;
    logic       last_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            run_q  <= 8'hFF;
            last_q <= 1'b0;
        end else begin
            last_q <= bus_clk_o;
            if (bus_clk_o != last_q) run_q <= 8'd1;
            else if (run_q != 8'hFF) run_q <= run_q + 8'd1;
        end
    end

    AST_RESET_LOW: assert property (@(posedge clk_i)
        rst_i |=> (!bus_clk_o && !tick_o)); // R1

    AST_TICK_ON_RISE: assert property (@(posedge clk_i) disable iff (rst_i)
        tick_o |-> (bus_clk_o && !$past(bus_clk_o))); // R8

    AST_RISE_HAS_TICK: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(bus_clk_o) |-> tick_o); // R8

    AST_MIN_PHASE: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_clk_o != $past(bus_clk_o)) |-> (run_q >= 8'd2)); // R7

    logic unused_in;
    assign unused_in = ^{ref_clk_i, sel_i};
endmodule

bind busclk_div busclk_div_chk u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .ref_clk_i(ref_clk_i),
    .sel_i    (sel_i),
    .bus_clk_o(bus_clk_o),
    .tick_o   (tick_o)
);

// File: tb/busclk_div_bench.sv
`timescale 1ns/1ps
module busclk_div_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       refc = 1'b0;
    logic [2:0] sel = 3'd0;
    logic       bclk, tick;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit mon_on = 0;

    always #5 clk = ~clk;                 // 100 MHz
    initial begin #3; forever #70 refc = ~refc; end  // 7 cycles high, 7 low

    busclk_div u_busclk_div (
        .clk_i(clk), .rst_i(rst), .ref_clk_i(refc), .sel_i(sel),
        .bus_clk_o(bclk), .tick_o(tick)
    );

    function automatic int exp_hi(logic [2:0] c);
        case (c)
            3'd1: return 2; 3'd2: return 2; 3'd3: return 3;
            3'd4: return 4; 3'd5: return 5; 3'd6: return 6;
            default: return 7;
        endcase
    endfunction
    function automatic int exp_lo(logic [2:0] c);
        case (c)
            3'd1: return 2; 3'd2: return 3; 3'd3: return 3;
            3'd4: return 4; 3'd5: return 5; 3'd6: return 6;
            default: return 7;
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Monitor: phase lengths (R7) and tick placement (R8), sampled at negedge.
    logic mprev = 1'b0;
    int   mrun  = 100;
    always @(negedge clk) begin
        if (mon_on) begin
            checks++;
            if (tick !== (bclk && !mprev)) begin
                errors++;
                $display("FAIL R8: tick actual %0b expected %0b", tick, bclk && !mprev);
            end
            if (bclk !== mprev) begin
                checks++;
                if (mrun < 2) begin
                    errors++;
                    $display("FAIL R7: phase length actual %0d expected >= 2", mrun);
                end
                mrun = 1;
            end else mrun++;
            mprev = bclk;
        end
    end

    task automatic wait_rise();
        logic p;
        p = bclk;
        forever begin
            @(negedge clk);
            if (bclk && !p) return;
            p = bclk;
        end
    endtask

    // Starting at a sampled rise, measure high and low lengths up to the next rise.
    task automatic measure(output int hi, output int lo);
        hi = 1; lo = 0;
        forever begin @(negedge clk); if (!bclk) break; hi++; end
        lo = 1;
        forever begin @(negedge clk); if (bclk) break; lo++; end
    endtask

    task automatic run_code(logic [2:0] c, string req);
        int hi, lo;
        @(negedge clk); sel = c;
        wait_rise();
        measure(hi, lo);
        measure(hi, lo);
        check({req, " high"}, hi, exp_hi(c));
        check({req, " low"},  lo, exp_lo(c));
    endtask

    // Change code one cycle after a rise; old period must finish unchanged (R6).
    task automatic switch_mid(logic [2:0] from_c, logic [2:0] to_c);
        int hi, lo;
        @(negedge clk); sel = from_c;
        wait_rise(); measure(hi, lo);
        @(negedge clk); sel = to_c;
        hi = 2; lo = 0;
        forever begin @(negedge clk); if (!bclk) break; hi++; end
        lo = 1;
        forever begin @(negedge clk); if (bclk) break; lo++; end
        if (exp_hi(to_c) == 7 && exp_hi(from_c) != 7) begin
            check("R6 old high kept", hi, exp_hi(from_c));
            checks++;
            if (lo < exp_lo(from_c)) begin
                errors++;
                $display("FAIL R6: low before reference actual %0d expected >= %0d", lo, exp_lo(from_c));
            end
        end else begin
            check("R6 old high kept", hi, exp_hi(from_c));
            check("R6 old low kept",  lo, exp_lo(from_c));
        end
        measure(hi, lo);
        check("R6 new high", hi, exp_hi(to_c));
        check("R6 new low",  lo, exp_lo(to_c));
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0429));
        repeat (6) @(negedge clk);
        check("R1 bus clock low in reset", int'(bclk), 0);
        check("R1 tick low in reset", int'(tick), 0);
        @(negedge clk); rst = 1'b0; mon_on = 1;

        for (int c = 1; c <= 6; c++) run_code(3'(c), "R2 R3 divide");
        run_code(3'd2, "R3 divide by five");
        run_code(3'd0, "R4 reference");
        run_code(3'd1, "R2 back to divide");
        run_code(3'd7, "R5 illegal code");

        switch_mid(3'd6, 3'd1);
        switch_mid(3'd1, 3'd6);
        switch_mid(3'd2, 3'd4);
        switch_mid(3'd1, 3'd0);
        switch_mid(3'd0, 3'd3);

        for (int i = 0; i < 40; i++) begin
            logic [2:0] c;
            int hi, lo;
            c = 3'($urandom_range(0, 7));
            repeat ($urandom_range(0, 15)) @(negedge clk);
            sel = c;
            wait_rise();
            measure(hi, lo);
            check("R2 R4 R5 random high", hi, exp_hi(c));
            check("R3 R4 random low", lo, exp_lo(c));
        end

        @(negedge clk); rst = 1'b1; mon_on = 0;
        repeat (2) @(negedge clk);
        check("R1 reset mid-run", int'(bclk | tick), 0);
        finish_run();
    end
endmodule